// File: doc/BRIEF.md
# Host-to-Controller Bidirectional Byte FIFO Link

This block sits between a host system bus and a local embedded controller. Bytes travel in both directions through two FIFO channels, and the two channels share one byte array of `DEPTH` entries (128 by default). The inbound channel carries bytes from the host to the controller. The outbound channel carries bytes from the controller to the host. A local boundary value sets how the array is divided. The inbound channel owns the lower `bnd` entries and the outbound channel owns the rest. The boundary can be moved only while both channels are empty.

The host uses a byte-wide slave data bus with a select, read and write strobes, and a two-bit register selector. There is also an active-low DMA acknowledge. While that acknowledge is low, host strobes go straight to the FIFO data path and the selector is ignored. In systems without a DMA controller the acknowledge is tied high.

The controller side uses valid/ready streams. On the inbound stream, `li_valid` stays high while data is waiting, and a byte leaves on any cycle where both `li_valid` and `li_ready` are high. On the outbound stream, `lo_ready` stays high while there is space, and a byte is taken on any cycle where both `lo_valid` and `lo_ready` are high. If `lo_ready` is low, the controller holds its byte. The controller can also post an immediate command byte for the host.

A single host interrupt collects three kinds of cause: a pending command, a sticky error, and FIFO service. FIFO service joins the interrupt only when DMA is off and the dedicated request pins are disabled.

Top module: `hostlink_fifo`

## Requirements
- R1: After reset, both channels are empty, the status byte reads 0x08, `irq` is low while `dma_en` is high, `li_valid` is low, `lo_ready` is high, and `loc_bnd_q` equals DEPTH/2.
- R2: The inbound channel holds exactly `bnd` bytes and the outbound channel holds exactly DEPTH-`bnd` bytes. A boundary write takes effect only when both channels are empty and the value lies in 1..DEPTH-1. Any other boundary write leaves `loc_bnd_q` unchanged.
- R3: A host write pushes `host_wdata` into the inbound channel in two cases: when `host_dack_n` is low, whatever `host_sel` and `host_addr` are; or when `host_sel` is high with `host_addr`=0. A write with `host_sel` low and `host_dack_n` high pushes nothing. Bytes reach `li_data` in arrival order.
- R4: A host read drives the oldest outbound byte on `host_rdata` and removes it. This happens when `host_dack_n` is low, or when `host_sel` is high with `host_addr`=0. Bytes leave in the order they were pushed.
- R5: A host write to a full inbound channel is dropped and sets the sticky overrun flag (status bit 1).
- R6: A host data read from an empty outbound channel returns the last byte removed (0 if none has been removed since reset) and sets the underrun flag (status bit 2).
- R7: A local command write (`loc_cmd_we`) stores `loc_cmd_data` and sets the command flag (status bit 0). A host read with `host_sel` high and `host_addr`=2 returns the stored byte.
- R8: A host read with `host_sel` high and `host_addr`=1 returns the status byte {3'b0, outbound-not-empty (bit 4), inbound-not-full (bit 3), underrun, overrun, command}. The read clears bits 0 to 2 from the next cycle. Bits 3 and 4 keep following the channel levels.
- R9: `in_req` equals inbound-not-full and `out_req` equals outbound-not-empty while `req_pins_en` is high. Both are low while `req_pins_en` is low.
- R10: `irq` is high when the command, overrun or underrun flag is set. When `dma_en` and `req_pins_en` are both low, `irq` is also high while status bit 3 or bit 4 is set.
- R11: `li_valid` is high exactly when the inbound channel holds data. `lo_ready` is high exactly when the outbound channel has space. Back-pressure follows the valid/ready rule: a byte moves only on a cycle where both valid and ready are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host select for register-addressed accesses |
| host_addr | input | 2 | Host register selector: 0 data, 1 status, 2 command |
| host_dack_n | input | 1 | Active-low DMA acknowledge; selects the FIFO data path directly |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid during the read strobe cycle |
| irq | output | 1 | Host interrupt |
| in_req | output | 1 | Dedicated inbound service request |
| out_req | output | 1 | Dedicated outbound service request |
| dma_en | input | 1 | Host DMA enabled |
| req_pins_en | input | 1 | Dedicated request pins enabled |
| li_valid | output | 1 | Inbound byte available to the controller |
| li_ready | input | 1 | Controller accepts the inbound byte |
| li_data | output | 8 | Inbound byte |
| lo_valid | input | 1 | Controller offers an outbound byte |
| lo_ready | output | 1 | Outbound channel has space |
| lo_data | input | 8 | Outbound byte |
| loc_cmd_we | input | 1 | Controller posts an immediate command byte |
| loc_cmd_data | input | 8 | Immediate command byte |
| loc_bnd_we | input | 1 | Controller writes the boundary |
| loc_bnd_data | input | AW | Requested boundary value |
| loc_bnd_q | output | AW | Current boundary value |

## Verification
Some properties are checked by assertions on every cycle: occupancy never exceeds the channel's current capacity; pushes and pops are gated by full and empty; the two write ports never hit the same entry; the boundary stays put while either channel holds data; overrun stays set until a status read; an empty-channel host read always sets underrun; and a DMA write into a non-full channel always leaves data behind. Other behaviour needs the bench's scenarios. These are byte ordering through every boundary split, the exact capacity of each channel, the last-byte value returned on underrun, the clear-on-read split between sticky and level status bits, and the interrupt routing across the DMA and request-pin settings.

// File: rtl/hlf_pkg.sv
package hlf_pkg;
  typedef enum logic [1:0] {
    HREG_DATA = 2'd0,
    HREG_STAT = 2'd1,
    HREG_CMD  = 2'd2,
    HREG_NONE = 2'd3
  } hreg_e;

  localparam int ST_CMD    = 0;
  localparam int ST_OVR    = 1;
  localparam int ST_UNR    = 2;
  localparam int ST_INSVC  = 3;
  localparam int ST_OUTSVC = 4;
endpackage

// File: rtl/hlf_dual_ram.sv
module hlf_dual_ram #(
  parameter int DEPTH = 128,
  parameter int W     = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_a,
  input  logic [AW-1:0] wa_a,
  input  logic [W-1:0]  wd_a,
  input  logic          we_b,
  input  logic [AW-1:0] wa_b,
  input  logic [W-1:0]  wd_b,
  input  logic [AW-1:0] ra_a,
  output logic [W-1:0]  rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_b
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_a) mem[wa_a] <= wd_a;
    if (we_b) mem[wa_b] <= wd_b;
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];

  // The two channel regions never overlap, so the two writers never collide
  assert_disjoint_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a && we_b) |-> (wa_a != wa_b));
endmodule

// File: rtl/hlf_fifo_ctrl.sv
module hlf_fifo_ctrl #(
  parameter int AW = 7,
  parameter int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wr_off,
  output logic [AW-1:0] rd_off,
  output logic          empty,
  output logic          full
);
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] o, input logic [CW-1:0] c);
    return ({1'b0, o} == c - 1'b1) ? '0 : o + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_off <= '0;
      rd_off <= '0;
      count  <= '0;
    end else begin
      if (push) wr_off <= step(wr_off, cap);
      if (pop)  rd_off <= step(rd_off, cap);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign empty = (count == '0);
  assign full  = (count == cap);

  assert_count_le_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cap);
  assert_push_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_pop_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/hlf_cause.sv
module hlf_cause #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_cmd,
  input  logic [W-1:0] cmd_in,
  input  logic         set_ovr,
  input  logic         set_unr,
  input  logic         stat_rd,
  input  logic         in_svc,
  input  logic         out_svc,
  input  logic         dma_en,
  input  logic         req_pins_en,
  output logic [W-1:0] cmd_q,
  output logic [7:0]   status,
  output logic         irq,
  output logic         in_req,
  output logic         out_req
);
  import hlf_pkg::*;

  logic cmd_p, ovr_p, unr_p;
  logic svc_route;

  // A new event in the same cycle as a status read survives the clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_p <= 1'b0;
      ovr_p <= 1'b0;
      unr_p <= 1'b0;
      cmd_q <= '0;
    end else begin
      cmd_p <= (cmd_p && !stat_rd) || set_cmd;
      ovr_p <= (ovr_p && !stat_rd) || set_ovr;
      unr_p <= (unr_p && !stat_rd) || set_unr;
      if (set_cmd) cmd_q <= cmd_in;
    end
  end

  always_comb begin
    status            = '0;
    status[ST_CMD]    = cmd_p;
    status[ST_OVR]    = ovr_p;
    status[ST_UNR]    = unr_p;
    status[ST_INSVC]  = in_svc;
    status[ST_OUTSVC] = out_svc;
  end

  assign svc_route = !dma_en && !req_pins_en;
  assign irq       = cmd_p || ovr_p || unr_p || (svc_route && (in_svc || out_svc));
  assign in_req    = req_pins_en && in_svc;
  assign out_req   = req_pins_en && out_svc;

  assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_p && !stat_rd) |=> ovr_p);
  assert_cmd_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_cmd |=> (cmd_p && irq));
endmodule

// File: rtl/hostlink_fifo.sv
module hostlink_fifo #(
  parameter int DEPTH = 128,
  parameter int W     = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic [1:0]    host_addr,
  input  logic          host_dack_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [W-1:0]  host_wdata,
  output logic [W-1:0]  host_rdata,
  output logic          irq,
  output logic          in_req,
  output logic          out_req,
  input  logic          dma_en,
  input  logic          req_pins_en,
  output logic          li_valid,
  input  logic          li_ready,
  output logic [W-1:0]  li_data,
  input  logic          lo_valid,
  output logic          lo_ready,
  input  logic [W-1:0]  lo_data,
  input  logic          loc_cmd_we,
  input  logic [W-1:0]  loc_cmd_data,
  input  logic          loc_bnd_we,
  input  logic [AW-1:0] loc_bnd_data,
  output logic [AW-1:0] loc_bnd_q
);
  import hlf_pkg::*;

  localparam int CW = AW + 1;
  localparam int NCH = 2;   // channel 0 inbound, channel 1 outbound
  localparam int CH_IN = 0;
  localparam int CH_OUT = 1;

  hreg_e hsel;
  logic  via_dma, via_sel;
  logic  data_wr, data_rd, stat_rd, cmd_rd;
  logic  bnd_ok, both_empty;
  logic [AW-1:0] bnd_q;
  logic [W-1:0]  last_out, out_head, cmd_q;
  logic [7:0]    status;

  logic [NCH-1:0] push, pop, empty, full;
  logic [CW-1:0]  cap    [NCH];
  logic [AW-1:0]  wr_off [NCH];
  logic [AW-1:0]  rd_off [NCH];

  // Host access decode: DMA acknowledge bypasses the register selector
  assign hsel    = hreg_e'(host_addr);
  assign via_dma = !host_dack_n;
  assign via_sel = host_sel && host_dack_n;
  assign data_wr = host_wr && (via_dma || (via_sel && hsel == HREG_DATA));
  assign data_rd = host_rd && (via_dma || (via_sel && hsel == HREG_DATA));
  assign stat_rd = host_rd && via_sel && hsel == HREG_STAT;
  assign cmd_rd  = host_rd && via_sel && hsel == HREG_CMD;

  assign push[CH_IN]  = data_wr && !full[CH_IN];
  assign pop[CH_IN]   = li_valid && li_ready;
  assign push[CH_OUT] = lo_valid && lo_ready;
  assign pop[CH_OUT]  = data_rd && !empty[CH_OUT];

  assign cap[CH_IN]  = CW'(bnd_q);
  assign cap[CH_OUT] = CW'(DEPTH) - CW'(bnd_q);

  // Boundary register: moves only with both channels drained
  assign both_empty = empty[CH_IN] && empty[CH_OUT];
  assign bnd_ok = loc_bnd_we && both_empty && (loc_bnd_data != '0)
                  && (CW'(loc_bnd_data) < CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) bnd_q <= AW'(DEPTH / 2);
    else if (bnd_ok) bnd_q <= loc_bnd_data;
  end
  assign loc_bnd_q = bnd_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    hlf_fifo_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (bnd_ok),
      .cap   (cap[c]),
      .push  (push[c]),
      .pop   (pop[c]),
      .wr_off(wr_off[c]),
      .rd_off(rd_off[c]),
      .empty (empty[c]),
      .full  (full[c])
    );
  end

  hlf_dual_ram #(.DEPTH(DEPTH), .W(W), .AW(AW)) u_ram (
    .clk  (clk),
    .rst_n(rst_n),
    .we_a (push[CH_IN]),
    .wa_a (wr_off[CH_IN]),
    .wd_a (host_wdata),
    .we_b (push[CH_OUT]),
    .wa_b (bnd_q + wr_off[CH_OUT]),
    .wd_b (lo_data),
    .ra_a (rd_off[CH_IN]),
    .rd_a (li_data),
    .ra_b (bnd_q + rd_off[CH_OUT]),
    .rd_b (out_head)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) last_out <= '0;
    else if (pop[CH_OUT]) last_out <= out_head;
  end

  assign li_valid = !empty[CH_IN];
  assign lo_ready = !full[CH_OUT];

  hlf_cause #(.W(W)) u_cause (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_cmd    (loc_cmd_we),
    .cmd_in     (loc_cmd_data),
    .set_ovr    (data_wr && full[CH_IN]),
    .set_unr    (data_rd && empty[CH_OUT]),
    .stat_rd    (stat_rd),
    .in_svc     (!full[CH_IN]),
    .out_svc    (!empty[CH_OUT]),
    .dma_en     (dma_en),
    .req_pins_en(req_pins_en),
    .cmd_q      (cmd_q),
    .status     (status),
    .irq        (irq),
    .in_req     (in_req),
    .out_req    (out_req)
  );

  always_comb begin
    host_rdata = '0;
    if (data_rd)      host_rdata = empty[CH_OUT] ? last_out : out_head;
    else if (stat_rd) host_rdata = status;
    else if (cmd_rd)  host_rdata = cmd_q;
  end

  assert_bnd_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !both_empty |=> $stable(bnd_q));
  assert_underrun_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && empty[CH_OUT]) |=> (status[ST_UNR] && irq));
  assert_dma_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (via_dma && host_wr && !full[CH_IN]) |=> li_valid);
endmodule

// File: tb/hostlink_fifo_tb.sv
module hostlink_fifo_tb;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel = 0, host_dack_n = 1, host_wr = 0, host_rd = 0;
  logic [1:0] host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic irq, in_req, out_req;
  logic dma_en = 1, req_pins_en = 0;
  logic li_valid, li_ready = 0, lo_valid = 0, lo_ready;
  logic [7:0] li_data, lo_data = 0;
  logic loc_cmd_we = 0, loc_bnd_we = 0;
  logic [7:0] loc_cmd_data = 0;
  logic [AW-1:0] loc_bnd_data = 0, loc_bnd_q;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hostlink_fifo #(.DEPTH(DEPTH), .W(8), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_addr(host_addr),
    .host_dack_n(host_dack_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
    .in_req(in_req), .out_req(out_req), .dma_en(dma_en), .req_pins_en(req_pins_en),
    .li_valid(li_valid), .li_ready(li_ready), .li_data(li_data),
    .lo_valid(lo_valid), .lo_ready(lo_ready), .lo_data(lo_data),
    .loc_cmd_we(loc_cmd_we), .loc_cmd_data(loc_cmd_data),
    .loc_bnd_we(loc_bnd_we), .loc_bnd_data(loc_bnd_data), .loc_bnd_q(loc_bnd_q)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(logic dn, logic sel, logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    host_dack_n = dn; host_sel = sel; host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0; host_dack_n = 1; host_sel = 0;
  endtask

  task automatic hr(logic dn, logic sel, logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_dack_n = dn; host_sel = sel; host_addr = a; host_rd = 1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 0; host_dack_n = 1; host_sel = 0;
  endtask

  task automatic lpop(output logic v, output logic [7:0] d);
    @(negedge clk);
    li_ready = 1;
    #1 v = li_valid; d = li_data;
    @(negedge clk);
    li_ready = 0;
  endtask

  task automatic lpush(logic [7:0] d, output logic r);
    @(negedge clk);
    lo_valid = 1; lo_data = d;
    #1 r = lo_ready;
    @(negedge clk);
    lo_valid = 0;
  endtask

  task automatic setb(logic [AW-1:0] b);
    @(negedge clk);
    loc_bnd_we = 1; loc_bnd_data = b;
    @(negedge clk);
    loc_bnd_we = 0;
  endtask

  task automatic settle;
    @(negedge clk);
    #1;
  endtask

  function automatic logic [7:0] pin(int b, int i);
    return 8'((b * 17 + i * 3) & 255);
  endfunction
  function automatic logic [7:0] pout(int b, int i);
    return 8'((b * 29 + i * 5 + 128) & 255);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    // R1 reset state
    chk("R1 bnd", int'(loc_bnd_q), DEPTH / 2);
    chk("R1 irq", int'(irq), 0);
    chk("R1 li_valid", int'(li_valid), 0);
    chk("R1 lo_ready", int'(lo_ready), 1);
    hr(1, 1, 2'd1, d);
    chk("R1 status", int'(d), 8'h08);

    // R6 underrun straight after reset returns zero
    hr(0, 0, 2'd0, d);
    chk("R6 empty read after reset", int'(d), 0);
    hr(1, 1, 2'd1, d);
    chk("R6 underrun flag", int'(d), 8'h0C);

    // Sweep every boundary split
    for (int b = 1; b < DEPTH; b++) begin
      setb(AW'(b));
      settle();
      chk("R2 bnd taken", int'(loc_bnd_q), b);
      for (int i = 0; i <= b; i++)
        hw((i % 2) ? 1'b0 : 1'b1, (i % 2) ? 1'b0 : 1'b1, 2'd0, pin(b, i));
      hr(1, 1, 2'd1, d);
      chk("R5 R2 overrun and full", int'(d), 8'h02);
      hr(1, 1, 2'd1, d);
      chk("R8 clear on read", int'(d), 8'h00);
      for (int i = 0; i < b; i++) begin
        lpop(v, d);
        chk("R11 li_valid", int'(v), 1);
        chk("R3 inbound order", int'(d), int'(pin(b, i)));
      end
      lpop(v, d);
      chk("R11 drained", int'(v), 0);
      for (int i = 0; i <= DEPTH - b; i++) begin
        lpush(pout(b, i), v);
        chk("R2 R11 outbound space", int'(v), (i < DEPTH - b) ? 1 : 0);
      end
      hr(1, 1, 2'd1, d);
      chk("R9 service bits", int'(d), 8'h18);
      for (int i = 0; i < DEPTH - b; i++) begin
        hr((i % 2) ? 1'b0 : 1'b1, (i % 2) ? 1'b0 : 1'b1, 2'd0, d);
        chk("R4 outbound order", int'(d), int'(pout(b, i)));
      end
      hr(0, 0, 2'd0, d);
      chk("R6 last byte on underrun", int'(d), int'(pout(b, DEPTH - b - 1)));
      hr(1, 1, 2'd1, d);
      chk("R6 underrun status", int'(d), 8'h0C);
      hr(1, 1, 2'd1, d);
      chk("R8 level bit remains", int'(d), 8'h08);
    end

    // R2 boundary rejected while data present, and value zero rejected
    hw(0, 0, 2'd0, 8'h33);
    setb(AW'(3));
    settle();
    chk("R2 reject non-empty", int'(loc_bnd_q), DEPTH - 1);
    lpop(v, d);
    chk("R3 byte kept", int'(d), 8'h33);
    setb('0);
    settle();
    chk("R2 reject zero", int'(loc_bnd_q), DEPTH - 1);
    setb(AW'(4));
    settle();
    chk("R2 accept", int'(loc_bnd_q), 4);

    // R3 DMA ignores selector; strobe without select or ack does nothing
    hw(0, 1, 2'd1, 8'hA5);
    lpop(v, d);
    chk("R3 dma ignores addr", int'(d), 8'hA5);
    hw(1, 0, 2'd0, 8'h11);
    settle();
    chk("R3 unselected write ignored", int'(li_valid), 0);

    // R7 immediate command
    @(negedge clk);
    loc_cmd_we = 1; loc_cmd_data = 8'h5A;
    @(negedge clk);
    loc_cmd_we = 0;
    #1 chk("R7 irq on command", int'(irq), 1);
    hr(1, 1, 2'd1, d);
    chk("R7 command bit", int'(d), 8'h09);
    hr(1, 1, 2'd2, d);
    chk("R7 command byte", int'(d), 8'h5A);
    settle();
    chk("R8 irq cleared", int'(irq), 0);

    // R5 R10 error raises irq with DMA on
    for (int i = 0; i < 5; i++) hw(0, 0, 2'd0, 8'(i));
    settle();
    chk("R10 irq on overrun", int'(irq), 1);
    hr(1, 1, 2'd1, d);
    chk("R5 overrun status", int'(d), 8'h02);
    settle();
    chk("R10 irq after clear full", int'(irq), 0);

    // R9 R10 service routing, inbound full and outbound empty
    dma_en = 0; req_pins_en = 0;
    settle();
    chk("R10 no service when idle-full", int'(irq), 0);
    for (int i = 0; i < 4; i++) lpop(v, d);
    settle();
    chk("R10 service on irq", int'(irq), 1);
    chk("R9 pins off", int'(in_req), 0);
    req_pins_en = 1;
    settle();
    chk("R10 routed to pins", int'(irq), 0);
    chk("R9 in_req", int'(in_req), 1);
    chk("R9 out_req empty", int'(out_req), 0);
    lpush(8'h77, v);
    settle();
    chk("R9 out_req data", int'(out_req), 1);
    dma_en = 1; req_pins_en = 0;
    settle();
    chk("R10 dma on hides service", int'(irq), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule